// File: doc/BRIEF.md
# Two-Stage SPI Clock Prescaler

This block derives the serial clock of an SPI master from a fast reference clock. The division runs through two cascaded programmable stages. A linear stage divides by a 4-bit value plus one. Each time that stage wraps, it advances a binary stage that divides by two raised to a second 4-bit value. One SCLK period therefore lasts `(pre_sel + 1) * 2**post_sel` reference cycles. The linear factor ranges from 1 to 16 and the binary factor from 1 to 32768. In the enclosing control register, `pre_sel` comes from bits 15:12 and `post_sel` from bits 11:8. Software picks the two values for a target rate.

Besides the SCLK level, the block gives the shift logic a one-cycle `edge_tick`. This pulse marks both SCLK edges, so it runs at twice the SCLK rate. The counters run only while the block is enabled and an exchange is active. Otherwise SCLK rests at the programmed polarity. When both fields are zero, the reference clock itself is passed through, using both of its phases.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: With running = `enable` and `xfer_active` both high, the tick and SCLK pattern repeats every D = (`pre_sel`+1) * 2^`post_sel` reference cycles, for any D of at least 2. Here `pre_sel` is control bits 15:12 and `post_sel` is control bits 11:8.
- R2: Count the running cycles from position 0 in each period. `edge_tick` is high, for one cycle each time, at position 0 and at position floor(D/2), and low at every other position.
- R3: While running and D ≥ 2, `sclk` equals `cpol` XOR 1 at positions below floor(D/2), and equals `cpol` at the remaining positions.
- R4: While running with both fields zero, `edge_tick` is high in every cycle and `sclk` equals `cpol` XOR `clk`.
- R5: While not running, `sclk` equals `cpol` and `edge_tick` is low, including during reset. The first running cycle is position 0.
- R6: If either field changes while running, the cycle after the clock edge that first samples the new value is position 0 of the new divisor. The cycle in which the change is presented still follows the old divisor.
- R7: The largest binary factor is supported. With `pre_sel` = 0 and `post_sel` = 15, the period is 32768 cycles and the ticks fall at positions 0 and 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; when low, the counters are held cleared |
| xfer_active | input | 1 | High while an exchange is in progress |
| cpol | input | 1 | SCLK idle level |
| pre_sel | input | 4 | Linear stage value (divides by value + 1) |
| post_sel | input | 4 | Binary stage exponent (divides by 2^value) |
| edge_tick | output | 1 | One-cycle pulse at each SCLK edge |
| sclk | output | 1 | Serial clock level |

## Verification
If a stage counter held a wrong value, the fault would show at the ports within one period. Ticks would fall away from positions 0 and floor(D/2), or the SCLK high time would shift. The bench compares every cycle of two full periods against an arithmetic position model, for all 16 linear values and the first four binary exponents. A wrap compare that is off by one would move the second period's ticks by one cycle per period. A missed restart would leave the first tick after a field change at the old phase on the very next cycle.

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              xfer_active,
  input  logic              cpol,
  input  logic [PRE_W-1:0]  pre_sel,
  input  logic [POST_W-1:0] post_sel,
  output logic              edge_tick,
  output logic              sclk
);
  localparam int QW = (1 << POST_W) - 1;

  logic [PRE_W-1:0]  pre_q, pcnt, phalf;
  logic [POST_W-1:0] post_q;
  logic [QW-1:0]     qcnt, qmax, qhalf;
  logic [PRE_W:0]    pre_len;
  logic running, cfg_chg, bypass, pre_wrap, lead, trail, first_half;

  assign running  = enable & xfer_active;
  assign cfg_chg  = (pre_sel != pre_q) || (post_sel != post_q);
  assign bypass   = (pre_q == '0) && (post_q == '0);
  assign pre_wrap = (pcnt == pre_q);

  assign pre_len  = {1'b0, pre_q} + {{PRE_W{1'b0}}, 1'b1};
  assign phalf    = pre_len[PRE_W:1];
  assign qmax     = (QW'(1) << post_q) - QW'(1);
  assign qhalf    = (post_q == '0) ? '0 : (QW'(1) << (post_q - POST_W'(1)));

  assign lead       = (pcnt == '0) && (qcnt == '0);
  assign trail      = (post_q == '0) ? (pcnt == phalf) : ((qcnt == qhalf) && (pcnt == '0));
  assign first_half = (post_q == '0) ? (pcnt < phalf) : (qcnt < qhalf);

  assign edge_tick = running & (bypass | lead | trail);
  assign sclk      = running ? (cpol ^ (bypass ? clk : first_half)) : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
      pcnt   <= '0;
      qcnt   <= '0;
    end else begin
      pre_q  <= pre_sel;
      post_q <= post_sel;
      if (!running || cfg_chg) begin
        pcnt <= '0;
        qcnt <= '0;
      end else if (pre_wrap) begin
        pcnt <= '0;
        qcnt <= (qcnt == qmax) ? '0 : qcnt + QW'(1);
      end else begin
        pcnt <= pcnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk #(
  parameter int PRE_W  = 4,
  parameter int POST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              xfer_active,
  input logic              cpol,
  input logic [PRE_W-1:0]  pre_sel,
  input logic [POST_W-1:0] post_sel,
  input logic              edge_tick,
  input logic              sclk,
  input logic              bypass
);
  logic running, wide;
  assign running = enable & xfer_active;
  assign wide = (post_sel >= POST_W'(2)) || (post_sel == POST_W'(1) && pre_sel != '0) ||
                (pre_sel >= PRE_W'(3));

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (sclk == cpol && !edge_tick));

  p_bypass_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bypass) |-> edge_tick);

  p_tick_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_tick && wide && $stable(pre_sel) && $stable(post_sel)) |=> !edge_tick);

  p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !bypass && !$past(bypass) && !$stable(sclk)) |-> edge_tick);
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk #(.PRE_W(PRE_W), .POST_W(POST_W)) u_chk (.*);

// File: tb/spi_sclk_prescaler_tb.sv
module spi_sclk_prescaler_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic xfer_active = 1'b0;
  logic cpol = 1'b0;
  logic [3:0] pre_sel = '0;
  logic [3:0] post_sel = '0;
  logic edge_tick, sclk;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .xfer_active(xfer_active),
    .cpol(cpol), .pre_sel(pre_sel), .post_sel(post_sel),
    .edge_tick(edge_tick), .sclk(sclk)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic expect_pos(input int pos, input int d, input bit pol);
    int half = d / 2;
    chk("R1 R2 tick", int'(edge_tick), int'(pos == 0 || pos == half));
    chk("R3 sclk", int'(sclk), int'(pol ^ (pos < half)));
  endtask

  task automatic start_cfg(input int pre, input int post, input bit pol);
    @(negedge clk); xfer_active = 1'b0; enable = 1'b1; cpol = pol;
    #(CLK_PERIOD/4);
    chk("R5 idle sclk", int'(sclk), int'(pol));
    chk("R5 idle tick", int'(edge_tick), 0);
    @(negedge clk); pre_sel = 4'(pre); post_sel = 4'(post);
    @(negedge clk); xfer_active = 1'b1;
  endtask

  task automatic run_cfg(input int pre, input int post, input bit pol, input int n);
    int d = (pre + 1) << post;
    start_cfg(pre, post, pol);
    for (int i = 0; i < n; i++) begin
      if (d == 1) begin
        #(CLK_PERIOD/4);
        chk("R4 tick low phase", int'(edge_tick), 1);
        chk("R4 sclk low phase", int'(sclk), int'(pol));
        @(posedge clk); #(CLK_PERIOD/4);
        chk("R4 tick high phase", int'(edge_tick), 1);
        chk("R4 sclk high phase", int'(sclk), int'(!pol));
      end else begin
        #(CLK_PERIOD/4);
        expect_pos(i % d, d, pol);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R5 reset sclk", int'(sclk), 0);
    chk("R5 reset tick", int'(edge_tick), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int post = 0; post < 4; post++)
      for (int pre = 0; pre < 16; pre++)
        run_cfg(pre, post, bit'((pre ^ post) & 1), 2 * ((pre + 1) << post) + 1);

    // R5: dropping enable mid-period idles the output and restarts at position 0
    start_cfg(2, 1, 1'b1);
    for (int i = 0; i < 3; i++) begin #(CLK_PERIOD/4); expect_pos(i, 6, 1'b1); @(negedge clk); end
    enable = 1'b0;
    #(CLK_PERIOD/4);
    chk("R5 disabled sclk", int'(sclk), 1);
    chk("R5 disabled tick", int'(edge_tick), 0);
    @(negedge clk); enable = 1'b1;
    for (int i = 0; i < 7; i++) begin #(CLK_PERIOD/4); expect_pos(i % 6, 6, 1'b1); @(negedge clk); end

    // R6: a field change restarts the period on the following cycle
    start_cfg(3, 1, 1'b0);
    for (int i = 0; i < 3; i++) begin #(CLK_PERIOD/4); expect_pos(i, 8, 1'b0); @(negedge clk); end
    pre_sel = 4'd1;
    #(CLK_PERIOD/4);
    chk("R6 old divisor tick", int'(edge_tick), 0);
    chk("R6 old divisor sclk", int'(sclk), 1);
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      #(CLK_PERIOD/4);
      chk("R6 restart tick", int'(edge_tick), int'((i % 4) == 0 || (i % 4) == 2));
      chk("R6 restart sclk", int'(sclk), int'((i % 4) < 2));
      @(negedge clk);
    end

    // R7: largest binary factor
    start_cfg(0, 15, 1'b0);
    for (int i = 0; i <= 32768; i++) begin
      #(CLK_PERIOD/4);
      if (i == 0 || i == 16383 || i == 16384 || i == 32767 || i == 32768) begin
        chk("R7 tick", int'(edge_tick), int'(i == 0 || i == 16384 || i == 32768));
        chk("R7 sclk", int'(sclk), int'((i % 32768) < 16384));
      end
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule